// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache with Mixed Page Sizes

This block is a small, fully associative cache of virtual-to-physical translations that sits in front of a page table walker. Each entry carries a virtual page tag, an 8-bit address space identifier, a page-size code, a physical frame number, permission bits and a global flag. A lookup presents a virtual address and the current identifier. In the same cycle the block returns hit or miss, the physical address, the permissions and the size of the page that hit.

On a miss, an external walker fetches the mapping and writes it in through the fill port. Three page sizes are supported: 4 KB, 2 MB and 1 GB. A 4 KB entry placed inside a larger page takes precedence over it. Software can invalidate every entry at once, or only the non-global entries of one address space. Fills go to a free entry when there is one. When the cache is full, a rotating victim pointer picks the entry to replace.

Top module: `xlat_cache`

## Requirements
- R1: A lookup hits an entry only if the entry is valid, its tag matches and its identifier equals `lk_asid_i`. A non-global entry with the same page number but another identifier is ignored.
- R2: An entry filled with `fill_global_i`=1 matches any lookup identifier.
- R3: Size codes are 0 for 4 KB, 1 for 2 MB and 2 for 1 GB. The tag compares virtual address bits [38:12], [38:21] and [38:30] respectively.
- R4: On a hit, `pa_o` takes its offset bits (below bit 12, 21 or 30 according to the size) unchanged from `lk_va_i`. The bits above come from the stored frame number (in 4 KB units), whose low 9 or 18 bits are ignored for 2 MB and 1 GB pages. `perm_o` returns the stored permissions.
- R5: When entries of different sizes match one lookup, the smallest page wins and `size_o` reports its code.
- R6: `hit_o` and `miss_o` are both low while `lk_req_i` is low. `miss_o` is high when `lk_req_i` is high and no entry matches. `pa_o` and `perm_o` are zero unless `hit_o` is high.
- R7: `flush_all_i` invalidates every entry at the next clock edge.
- R8: `flush_asid_en_i` invalidates the non-global entries whose identifier equals `flush_asid_i`. Global entries and entries of other identifiers stay valid.
- R9: A fill goes to the lowest-indexed invalid entry. When all 16 entries are valid, it goes to a rotating victim that starts at entry 0 after reset and advances by one on each such replacement only.
- R10: A fill whose tag, identifier and size match a valid entry overwrites that entry. It consumes no victim.
- R11: After reset every entry is invalid. A fill in a cycle with any flush asserted is dropped.
- R12: A lookup reflects the contents before any fill in the same cycle. A fill is visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_req_i | input | 1 | Lookup request |
| lk_va_i | input | 39 | Lookup virtual address |
| lk_asid_i | input | 8 | Current address space identifier |
| hit_o | output | 1 | Lookup hit |
| miss_o | output | 1 | Lookup miss, walker should fetch |
| pa_o | output | 40 | Translated physical address |
| perm_o | output | 3 | Permission bits of the hit entry |
| size_o | output | 2 | Size code of the hit entry |
| fill_en_i | input | 1 | Write a translation |
| fill_vpn_i | input | 27 | Virtual page number (address bits 38:12) |
| fill_asid_i | input | 8 | Identifier of the filled entry |
| fill_size_i | input | 2 | Size code of the filled entry |
| fill_global_i | input | 1 | Entry matches every identifier |
| fill_pfn_i | input | 28 | Frame number in 4 KB units |
| fill_perm_i | input | 3 | Permission bits |
| flush_all_i | input | 1 | Invalidate all entries |
| flush_asid_en_i | input | 1 | Invalidate by identifier |
| flush_asid_i | input | 8 | Identifier to invalidate |

## Verification
Lookups sweep the page offset across each of the three sizes with stride patterns. These show whether offset bits pass through and which frame bits are ignored. Probes one page past the end of a large page and just below its base show where the tag mask ends. A full sweep of all 256 identifiers against two entries that share a page number separates correct identifier matching from a tag-only compare. A stepped sweep against a global entry shows the identifier is bypassed for it. A 4 KB page laid over a 2 MB page, probed inside and outside the overlay, separates size priority from index priority. Filling sixteen pages, then replacing and refilling, tells apart free-first allocation, rotation order, and overwrite of a duplicate without consuming a victim.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {PG_4K = 2'd0, PG_2M = 2'd1, PG_1G = 2'd2} pg_size_e;
  localparam int BASE_OFF = 12;
  localparam int LVL_BITS = 9;
endpackage

// File: rtl/xlat_entry.sv
module xlat_entry
  import xlat_pkg::*;
#(
  parameter int VPN_W  = 27,
  parameter int PFN_W  = 28,
  parameter int ASID_W = 8,
  parameter int PERM_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              clr_all_i,
  input  logic              clr_asid_en_i,
  input  logic [ASID_W-1:0] clr_asid_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic [1:0]        wr_size_i,
  input  logic              wr_glob_i,
  input  logic [PFN_W-1:0]  wr_pfn_i,
  input  logic [PERM_W-1:0] wr_perm_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  output logic              valid_o,
  output logic              hit_o,
  output logic              dup_o,
  output logic [1:0]        size_o,
  output logic [PFN_W-1:0]  pfn_o,
  output logic [PERM_W-1:0] perm_o
);
  logic              valid_q, glob_q;
  logic [VPN_W-1:0]  vpn_q, cmp_m;
  logic [ASID_W-1:0] asid_q;
  logic [1:0]        size_q;
  logic [PFN_W-1:0]  pfn_q;
  logic [PERM_W-1:0] perm_q;

  // larger pages ignore the low index levels of the tag
  always_comb begin
    cmp_m = '1;
    if (size_q == PG_2M) cmp_m[LVL_BITS-1:0] = '0;
    else if (size_q == PG_1G) cmp_m[2*LVL_BITS-1:0] = '0;
  end

  assign hit_o = valid_q && (((lk_vpn_i ^ vpn_q) & cmp_m) == '0) &&
                 (glob_q || (asid_q == lk_asid_i));
  assign dup_o = valid_q && (size_q == wr_size_i) && (asid_q == wr_asid_i) &&
                 (((wr_vpn_i ^ vpn_q) & cmp_m) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      glob_q  <= 1'b0;
      vpn_q   <= '0;
      asid_q  <= '0;
      size_q  <= PG_4K;
      pfn_q   <= '0;
      perm_q  <= '0;
    end else if (clr_all_i) begin
      valid_q <= 1'b0;
    end else if (wr_i) begin
      valid_q <= 1'b1;
      glob_q  <= wr_glob_i;
      vpn_q   <= wr_vpn_i;
      asid_q  <= wr_asid_i;
      size_q  <= wr_size_i;
      pfn_q   <= wr_pfn_i;
      perm_q  <= wr_perm_i;
    end else if (clr_asid_en_i && !glob_q && (asid_q == clr_asid_i)) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign size_o  = size_q;
  assign pfn_o   = pfn_q;
  assign perm_o  = perm_q;

  // R8
  clr_asid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_asid_en_i && !wr_i && valid_q && !glob_q && asid_q == clr_asid_i) |=> !valid_q);
  // R8
  keep_other_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_asid_en_i && !clr_all_i && valid_q && (glob_q || asid_q != clr_asid_i)) |=> valid_q);
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N_ENT = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_ENT-1:0] valid_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             full_o
);
  logic [IDX_W-1:0] rr_q, free_idx;

  always_comb begin
    free_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--)
      if (!valid_i[i]) free_idx = IDX_W'(i);
  end

  assign full_o = &valid_i;
  assign idx_o  = full_o ? rr_q : free_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else if (adv_i) rr_q <= (rr_q == IDX_W'(N_ENT - 1)) ? '0 : rr_q + 1'b1;
  end

  // R9
  victim_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (rr_q != $past(rr_q)));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int VA_W   = 39,
  parameter int PA_W   = 40,
  parameter int ASID_W = 8,
  parameter int N_ENT  = 16,
  parameter int PERM_W = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       lk_req_i,
  input  logic [VA_W-1:0]            lk_va_i,
  input  logic [ASID_W-1:0]          lk_asid_i,
  output logic                       hit_o,
  output logic                       miss_o,
  output logic [PA_W-1:0]            pa_o,
  output logic [PERM_W-1:0]          perm_o,
  output logic [1:0]                 size_o,
  input  logic                       fill_en_i,
  input  logic [VA_W-BASE_OFF-1:0]   fill_vpn_i,
  input  logic [ASID_W-1:0]          fill_asid_i,
  input  logic [1:0]                 fill_size_i,
  input  logic                       fill_global_i,
  input  logic [PA_W-BASE_OFF-1:0]   fill_pfn_i,
  input  logic [PERM_W-1:0]          fill_perm_i,
  input  logic                       flush_all_i,
  input  logic                       flush_asid_en_i,
  input  logic [ASID_W-1:0]          flush_asid_i
);
  localparam int VPN_W = VA_W - BASE_OFF;
  localparam int PFN_W = PA_W - BASE_OFF;
  localparam int IDX_W = $clog2(N_ENT);

  logic [N_ENT-1:0]             valid_vec, hit_vec, dup_vec, small_vec;
  logic [N_ENT-1:0][1:0]        size_arr;
  logic [N_ENT-1:0][PFN_W-1:0]  pfn_arr;
  logic [N_ENT-1:0][PERM_W-1:0] perm_arr;
  logic                         fill_ok, any_dup, full, found;
  logic [IDX_W-1:0]             dup_idx, vict_idx, wr_idx;
  logic [PFN_W-1:0]             sel_pfn;
  logic [PERM_W-1:0]            sel_perm;
  logic [1:0]                   sel_size;
  logic [PA_W-1:0]              off_m, va_ext, pa_raw;

  assign fill_ok = fill_en_i && !flush_all_i && !flush_asid_en_i;

  for (genvar gi = 0; gi < N_ENT; gi++) begin : g_ent
    xlat_entry #(.VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W), .PERM_W(PERM_W)) u_ent (
      .clk_i, .rst_ni,
      .wr_i          (fill_ok && (wr_idx == IDX_W'(gi))),
      .clr_all_i     (flush_all_i),
      .clr_asid_en_i (flush_asid_en_i),
      .clr_asid_i    (flush_asid_i),
      .wr_vpn_i      (fill_vpn_i),
      .wr_asid_i     (fill_asid_i),
      .wr_size_i     (fill_size_i),
      .wr_glob_i     (fill_global_i),
      .wr_pfn_i      (fill_pfn_i),
      .wr_perm_i     (fill_perm_i),
      .lk_vpn_i      (lk_va_i[VA_W-1:BASE_OFF]),
      .lk_asid_i     (lk_asid_i),
      .valid_o       (valid_vec[gi]),
      .hit_o         (hit_vec[gi]),
      .dup_o         (dup_vec[gi]),
      .size_o        (size_arr[gi]),
      .pfn_o         (pfn_arr[gi]),
      .perm_o        (perm_arr[gi])
    );
    assign small_vec[gi] = hit_vec[gi] && (size_arr[gi] == PG_4K);
  end

  xlat_victim #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_vict (
    .clk_i, .rst_ni,
    .valid_i (valid_vec),
    .adv_i   (fill_ok && !any_dup && full),
    .idx_o   (vict_idx),
    .full_o  (full)
  );

  always_comb begin
    dup_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--)
      if (dup_vec[i]) dup_idx = IDX_W'(i);
  end
  assign any_dup = |dup_vec;
  assign wr_idx  = any_dup ? dup_idx : vict_idx;

  // size outranks index: 4K first, then 2M, then 1G
  always_comb begin
    found    = 1'b0;
    sel_pfn  = '0;
    sel_perm = '0;
    sel_size = PG_4K;
    for (int s = 0; s < 3; s++)
      for (int i = 0; i < N_ENT; i++)
        if (!found && hit_vec[i] && size_arr[i] == 2'(s)) begin
          found    = 1'b1;
          sel_pfn  = pfn_arr[i];
          sel_perm = perm_arr[i];
          sel_size = size_arr[i];
        end
  end

  always_comb begin
    off_m = '0;
    off_m[BASE_OFF-1:0] = '1;
    if (sel_size == PG_2M) off_m[BASE_OFF+LVL_BITS-1:0] = '1;
    if (sel_size == PG_1G) off_m[BASE_OFF+2*LVL_BITS-1:0] = '1;
  end

  assign va_ext = PA_W'(lk_va_i);
  assign pa_raw = ({sel_pfn, {BASE_OFF{1'b0}}} & ~off_m) | (va_ext & off_m);

  assign hit_o  = lk_req_i && found;
  assign miss_o = lk_req_i && !found;
  assign pa_o   = hit_o ? pa_raw : '0;
  assign perm_o = hit_o ? sel_perm : '0;
  assign size_o = hit_o ? sel_size : PG_4K;

  // R5
  small_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && size_o != PG_4K) |-> (small_vec == '0));
  // R10
  no_dup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dup_vec));
  // R9
  fill_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_ok && !any_dup && !full) |=> ($countones(valid_vec) == $past($countones(valid_vec)) + 1));
  // R7
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i |=> (valid_vec == '0));
endmodule

// File: tb/xlat_cache_test.sv
module xlat_cache_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        lk_req = 1'b0;
  logic [38:0] lk_va = '0;
  logic [7:0]  lk_asid = '0;
  logic        hit, miss;
  logic [39:0] pa;
  logic [2:0]  perm;
  logic [1:0]  size;
  logic        fill_en = 1'b0, fill_glob = 1'b0;
  logic [26:0] fill_vpn = '0;
  logic [7:0]  fill_asid = '0;
  logic [1:0]  fill_size = '0;
  logic [27:0] fill_pfn = '0;
  logic [2:0]  fill_perm = '0;
  logic        fl_all = 1'b0, fl_asid_en = 1'b0;
  logic [7:0]  fl_asid = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [38:0] VA_A  = 39'h12_3456_7000;
  localparam logic [38:0] VA_2M = 39'h00_8020_0000;
  localparam logic [38:0] VA_1G = 39'h40_0000_0000;
  localparam logic [38:0] VA_G  = 39'h7F_FFFF_F000;

  always #10 clk = ~clk;

  xlat_cache uut (
    .clk_i(clk), .rst_ni(rst_n), .lk_req_i(lk_req), .lk_va_i(lk_va), .lk_asid_i(lk_asid),
    .hit_o(hit), .miss_o(miss), .pa_o(pa), .perm_o(perm), .size_o(size),
    .fill_en_i(fill_en), .fill_vpn_i(fill_vpn), .fill_asid_i(fill_asid),
    .fill_size_i(fill_size), .fill_global_i(fill_glob), .fill_pfn_i(fill_pfn),
    .fill_perm_i(fill_perm), .flush_all_i(fl_all), .flush_asid_en_i(fl_asid_en),
    .flush_asid_i(fl_asid)
  );

  function automatic logic [39:0] epa(logic [27:0] pfn, logic [38:0] va, int sz);
    int ob = 12 + 9 * sz;
    logic [63:0] m = (64'd1 << ob) - 64'd1;
    return 40'(((64'(pfn) << 12) & ~m) | (64'(va) & m));
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic fill(input logic [38:0] va, input logic [7:0] a, input int sz,
                      input logic [27:0] pfn, input logic [2:0] pm, input logic g);
    @(negedge clk);
    fill_en = 1; fill_vpn = va[38:12]; fill_asid = a; fill_size = 2'(sz);
    fill_pfn = pfn; fill_perm = pm; fill_glob = g;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic look(input logic [38:0] va, input logic [7:0] a);
    @(negedge clk);
    lk_req = 1; lk_va = va; lk_asid = a;
    #2;
  endtask

  task automatic hitchk(input string tag, input logic [38:0] va, input logic [7:0] a,
                        input logic [27:0] pfn, input int sz, input logic [2:0] pm);
    look(va, a);
    chk({tag, " hit"}, 64'(hit), 64'd1);
    chk({tag, " pa"}, 64'(pa), 64'(epa(pfn, va, sz)));
    chk({tag, " perm"}, 64'(perm), 64'(pm));
    chk({tag, " size"}, 64'(size), 64'(sz));
  endtask

  task automatic misschk(input string tag, input logic [38:0] va, input logic [7:0] a);
    look(va, a);
    chk({tag, " hit"}, 64'(hit), 64'd0);
    chk({tag, " miss"}, 64'(miss), 64'd1);
    chk({tag, " pa"}, 64'(pa), 64'd0);
  endtask

  task automatic pulse_all();
    @(negedge clk); fl_all = 1;
    @(negedge clk); fl_all = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    misschk("R11 reset", VA_A, 8'd5);

    fill(VA_A, 8'd5, 0, 28'hABCDE, 3'b011, 0);
    fill(VA_2M, 8'd5, 1, 28'h33DFF, 3'b101, 0);
    fill(VA_1G, 8'd5, 2, 28'hAAAAAAA, 3'b001, 0);
    fill(VA_2M + 39'h5000, 8'd5, 0, 28'h77777, 3'b100, 0);
    fill(VA_G, 8'd9, 0, 28'h0F00F, 3'b111, 1);
    fill(VA_A, 8'd7, 0, 28'h55555, 3'b010, 0);

    // R4 4K offset sweep
    for (int k = 0; k < 16; k++)
      hitchk("R4 4k off", VA_A + 39'(k * 273), 8'd5, 28'hABCDE, 0, 3'b011);

    // R1 identifier sweep over a shared page number
    for (int a = 0; a < 256; a++) begin
      look(VA_A + 39'h123, 8'(a));
      if (a == 5) chk("R1 asid5 pa", 64'(pa), 64'(epa(28'hABCDE, VA_A + 39'h123, 0)));
      else if (a == 7) chk("R1 asid7 pa", 64'(pa), 64'(epa(28'h55555, VA_A + 39'h123, 0)));
      else chk("R1 other asid hit", 64'(hit), 64'd0);
    end

    // R3 R5 2M sweep with a 4K overlay at page 5
    for (int k = 0; k < 32; k++) begin
      logic [38:0] off = 39'((k * 32'h10F01) & 32'h1FFFFF);
      if (off[20:12] == 9'd5)
        hitchk("R5 overlay", VA_2M + off, 8'd5, 28'h77777, 0, 3'b100);
      else
        hitchk("R3 2m off", VA_2M + off, 8'd5, 28'h33DFF, 1, 3'b101);
    end
    hitchk("R5 overlay in", VA_2M + 39'h5123, 8'd5, 28'h77777, 0, 3'b100);
    hitchk("R5 overlay out", VA_2M + 39'h6123, 8'd5, 28'h33DFF, 1, 3'b101);
    misschk("R3 past 2m", VA_2M + 39'h200000, 8'd5);
    misschk("R3 below 2m", VA_2M - 39'd1, 8'd5);

    // R3 1G sweep
    for (int k = 0; k < 32; k++)
      hitchk("R3 1g off", VA_1G + 39'((k * 32'h01375A31) & 32'h3FFFFFFF), 8'd5,
             28'hAAAAAAA, 2, 3'b001);
    misschk("R3 past 1g", VA_1G + 39'h4000_0000, 8'd5);

    // R2 global entry under many identifiers
    for (int a = 0; a < 256; a += 17)
      hitchk("R2 global", VA_G + 39'h0AB, 8'(a), 28'h0F00F, 0, 3'b111);

    // R6 no request
    @(negedge clk); lk_req = 0; lk_va = VA_A; lk_asid = 8'd5; #2;
    chk("R6 idle hit", 64'(hit), 64'd0);
    chk("R6 idle miss", 64'(miss), 64'd0);
    chk("R6 idle perm", 64'(perm), 64'd0);

    // R8 flush identifier 5
    @(negedge clk); fl_asid_en = 1; fl_asid = 8'd5;
    @(negedge clk); fl_asid_en = 0;
    misschk("R8 4k gone", VA_A, 8'd5);
    misschk("R8 2m gone", VA_2M, 8'd5);
    misschk("R8 1g gone", VA_1G, 8'd5);
    misschk("R8 overlay gone", VA_2M + 39'h5000, 8'd5);
    hitchk("R8 other kept", VA_A, 8'd7, 28'h55555, 0, 3'b010);
    hitchk("R8 global kept", VA_G, 8'd5, 28'h0F00F, 0, 3'b111);

    // R7 flush all
    pulse_all();
    misschk("R7 asid7", VA_A, 8'd7);
    misschk("R7 global", VA_G, 8'd9);

    // R12 same-cycle fill is not seen until next cycle
    @(negedge clk);
    fill_en = 1; fill_vpn = VA_A[38:12]; fill_asid = 8'd5; fill_size = 2'd0;
    fill_pfn = 28'h12121; fill_perm = 3'b110; fill_glob = 0;
    lk_req = 1; lk_va = VA_A; lk_asid = 8'd5;
    #2 chk("R12 same cycle", 64'(hit), 64'd0);
    @(negedge clk); fill_en = 0;
    #2 chk("R12 next cycle", 64'(hit), 64'd1);

    // R11 fill dropped under flush
    @(negedge clk);
    fill_en = 1; fill_vpn = 27'h1; fill_asid = 8'd3; fill_size = 2'd0;
    fill_pfn = 28'h1; fl_all = 1;
    @(negedge clk); fill_en = 0; fl_all = 0;
    misschk("R11 fill under flush", 39'h1000, 8'd3);
    misschk("R11 flushed too", VA_A, 8'd5);

    // R9 free-first then rotation
    for (int i = 0; i < 16; i++) fill(39'(i) << 12, 8'd1, 0, 28'(32'h100 + i), 3'b001, 0);
    for (int i = 0; i < 16; i++)
      hitchk("R9 full set", (39'(i) << 12) + 39'h44, 8'd1, 28'(32'h100 + i), 0, 3'b001);
    fill(39'(16) << 12, 8'd1, 0, 28'h110, 3'b001, 0);
    misschk("R9 evict first", 39'h0, 8'd1);
    hitchk("R9 new in", 39'(16) << 12, 8'd1, 28'h110, 0, 3'b001);
    hitchk("R9 second kept", 39'(1) << 12, 8'd1, 28'h101, 0, 3'b001);

    // R10 refill overwrites in place
    fill(39'(16) << 12, 8'd1, 0, 28'h999, 3'b010, 0);
    hitchk("R10 overwrite", 39'(16) << 12, 8'd1, 28'h999, 0, 3'b010);
    hitchk("R10 no victim", 39'(1) << 12, 8'd1, 28'h101, 0, 3'b001);
    fill(39'(17) << 12, 8'd1, 0, 28'h111, 3'b001, 0);
    misschk("R9 evict next", 39'(1) << 12, 8'd1);
    hitchk("R9 third kept", 39'(2) << 12, 8'd1, 28'h102, 0, 3'b001);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule